// File: doc/BRIEF.md
# ALU With Condition Flags and Interrupt Gate

This block is the arithmetic core and status register of a small accumulator machine. Each cycle it takes an operation code, the accumulator and a memory operand, and produces an 8-bit result at once. At the clock edge it updates a condition register. That register holds a half-carry flag, an interrupt mask and the sign, zero and carry flags. Each flag is written only by the operations that own it. The whole register is available for pushing to the stack. It can be restored in parallel from a popped value by a return-from-interrupt or a pop operation.

The block also keeps two pending-request latches. One is for a software trap, which ignores the mask. The other is for a maskable interrupt, which waits while the mask is set. The block raises a service request toward the sequencer, and the sequencer answers with an acknowledge. That acknowledge is the interrupt entry strobe: it clears the granted latch and sets the mask in the same edge.

Top module: `ccr_core`

## Requirements
- R1: After reset the register reads 0xE8: bits 7..5 and the mask (bit 3) are 1, and the half-carry H (bit 4), sign N (bit 2), zero Z (bit 1) and carry C (bit 0) are 0. No service request is raised.
- R2: Bits 7..5 of the register always read 1. The top three bits of a restored value are ignored.
- R3: ADD (code 1) gives acc+mem, and ADC (code 2) gives acc+mem+C. Both set C to the carry out of bit 7 and H to the carry from bit 3 into bit 4, and clear H when there is no such carry.
- R4: SUB (code 3) gives acc-mem and sets C to 1 exactly when mem > acc. H is left unchanged.
- R5: AND (code 4), OR (code 5) and LD (code 6, result = mem) leave C and H unchanged.
- R6: Every arithmetic or logic operation (codes 1..6) sets N to bit 7 of the result and Z to 1 exactly when the result is zero.
- R7: SIM (code 7) sets the mask and RIM (code 8) clears it. Both leave the other flags unchanged. NOP (code 0) and codes 11..15 change nothing. For every non-arithmetic code the result equals acc.
- R8: IRET (code 9) and POPC (code 10) load H, I, N, Z and C from bits 4..0 of the restore input.
- R9: A maskable request is latched. It raises the service request only while the mask is 0, and it is held without loss while the mask is 1.
- R10: A trap request is latched and raises the service request whatever the mask. While it is pending it has priority, which is shown by the trap-select output.
- R11: An acknowledge while the service request is high clears the granted latch and sets the mask at that edge. A new request for the same latch in that same cycle leaves the latch pending. An acknowledge with no service request has no effect.
- R12: When an acknowledge is taken in the same cycle as SIM, RIM, IRET or POPC, the mask ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| mem_i | input | 8 | Memory operand |
| pop_i | input | 8 | Register value popped from the stack |
| trap_req_i | input | 1 | Software trap request pulse |
| irq_req_i | input | 1 | Maskable interrupt request pulse |
| svc_ack_i | input | 1 | Service acknowledge / interrupt entry strobe |
| result_o | output | 8 | Combinational operation result |
| cc_o | output | 8 | Full condition register, for pushing |
| flags_o | output | 5 | H, I, N, Z, C in bits 4..0 |
| svc_req_o | output | 1 | A pending request may be serviced |
| svc_trap_o | output | 1 | The serviceable request is the trap |

## Verification
Two pairs of functions can fall in one cycle. The first pair is an acknowledge and a fresh request for the same latch. The second pair is an acknowledge and an operation that writes the mask. The bench forces both pairs in directed steps: a maskable request arrives on the acknowledge edge, and an acknowledge is given with RIM and with IRET of a cleared mask. The random phase also lets acknowledges, requests and mask-writing codes coincide freely. Each cycle is judged against a bench model in which the latch keeps any same-cycle request and in which entry overrides the mask written by the operation.

// File: rtl/ccr_pkg.sv
// Package: shared operation codes, flag layout and register constants for
// the ALU/condition register block. Assumes an 8-bit condition register.
package ccr_pkg;
    localparam int CC_W  = 8;
    localparam int FL_W  = 5;
    localparam logic [2:0] CC_TOP = 3'b111;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SUB  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_LD   = 4'd6,
        OP_SIM  = 4'd7,
        OP_RIM  = 4'd8,
        OP_IRET = 4'd9,
        OP_POPC = 4'd10
    } op_e;

    typedef struct packed {
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RST = '{h: 1'b0, i: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};
endpackage

// File: rtl/ccr_alu.sv
// Module: combinational ALU. Computes the result of one operation and the
// flag values plus per-flag write enables. Assumes HB < DW (half carry taken
// from the carry into bit HB).
module ccr_alu
    import ccr_pkg::*;
#(
    parameter int DW = 8,
    parameter int HB = 4
) (
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] m_i,
    input  logic          c_i,
    output logic [DW-1:0] res_o,
    output logic          n_o,
    output logic          z_o,
    output logic          c_o,
    output logic          h_o,
    output logic          wr_nz_o,
    output logic          wr_c_o,
    output logic          wr_h_o
);
    op_e           op_w;
    logic          cin_w;
    logic [DW:0]   sum_w;
    logic [DW:0]   dif_w;
    logic [HB:0]   hsum_w;

    // Decode the opcode into the enum and select the carry-in
    always_comb begin
        op_w  = op_e'(op_i);
        cin_w = (op_w == OP_ADC) ? c_i : 1'b0;
    end

    // Adder, low-nibble adder for half carry, and subtractor
    always_comb begin
        sum_w  = {1'b0, a_i} + {1'b0, m_i} + {{DW{1'b0}}, cin_w};
        hsum_w = {1'b0, a_i[HB-1:0]} + {1'b0, m_i[HB-1:0]} + {{HB{1'b0}}, cin_w};
        dif_w  = {1'b0, a_i} - {1'b0, m_i};
    end

    // Result mux and flag write enables per operation
    always_comb begin
        res_o   = a_i;
        c_o     = c_i;
        h_o     = 1'b0;
        wr_nz_o = 1'b0;
        wr_c_o  = 1'b0;
        wr_h_o  = 1'b0;
        case (op_w)
            OP_ADD, OP_ADC: begin
                res_o   = sum_w[DW-1:0];
                c_o     = sum_w[DW];
                h_o     = hsum_w[HB];
                wr_nz_o = 1'b1;
                wr_c_o  = 1'b1;
                wr_h_o  = 1'b1;
            end
            OP_SUB: begin
                res_o   = dif_w[DW-1:0];
                c_o     = dif_w[DW];
                wr_nz_o = 1'b1;
                wr_c_o  = 1'b1;
            end
            OP_AND: begin
                res_o   = a_i & m_i;
                wr_nz_o = 1'b1;
            end
            OP_OR: begin
                res_o   = a_i | m_i;
                wr_nz_o = 1'b1;
            end
            OP_LD: begin
                res_o   = m_i;
                wr_nz_o = 1'b1;
            end
            default: res_o = a_i;
        endcase
    end

    // Sign and zero of the selected result
    always_comb begin
        n_o = res_o[DW-1];
        z_o = (res_o == '0);
    end
endmodule

// File: rtl/ccr_flags.sv
// Module: condition flag register. Applies the per-flag update policy:
// ALU-driven writes, mask set/clear, parallel restore, and interrupt entry.
// Assumes entry (enter_i) has the final say over the mask.
module ccr_flags
    import ccr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [CC_W-1:0] pop_i,
    input  logic         enter_i,
    input  logic         n_i,
    input  logic         z_i,
    input  logic         c_i,
    input  logic         h_i,
    input  logic         wr_nz_i,
    input  logic         wr_c_i,
    input  logic         wr_h_i,
    output flags_t       fl_o
);
    op_e    op_w;
    flags_t fl_q;
    flags_t fl_d;
    logic   unused_pop_top;

    // Top restore bits carry no state and are dropped here
    assign unused_pop_top = ^pop_i[CC_W-1:FL_W];

    // Next-state logic: restore, ALU writes, mask ops, then entry
    always_comb begin
        op_w = op_e'(op_i);
        fl_d = fl_q;
        if (op_w == OP_IRET || op_w == OP_POPC) begin
            fl_d = flags_t'(pop_i[FL_W-1:0]);
        end
        if (wr_nz_i) begin
            fl_d.n = n_i;
            fl_d.z = z_i;
        end
        if (wr_c_i) fl_d.c = c_i;
        if (wr_h_i) fl_d.h = h_i;
        if (op_w == OP_SIM) fl_d.i = 1'b1;
        if (op_w == OP_RIM) fl_d.i = 1'b0;
        if (enter_i)        fl_d.i = 1'b1;
    end

    // Register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= FLAGS_RST;
        else        fl_q <= fl_d;
    end

    assign fl_o = fl_q;
endmodule

// File: rtl/ccr_pend.sv
// Module: pending-request latches with fixed priority (index 0 highest).
// Sources flagged in MASKABLE are gated by mask_i; others are not. A request
// arriving in the acknowledge cycle keeps its latch set.
module ccr_pend #(
    parameter int          N        = 2,
    parameter logic [N-1:0] MASKABLE = 2'b10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         mask_i,
    input  logic         ack_i,
    output logic [N-1:0] grant_o,
    output logic         take_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] elig_w;
    logic [N-1:0] clr_w;

    // Eligibility per source: pending and not blocked by the mask
    generate
        for (genvar k = 0; k < N; k++) begin : g_elig
            assign elig_w[k] = pend_q[k] & (~MASKABLE[k] | ~mask_i);
        end
    endgenerate

    // Fixed-priority pick of the lowest eligible index
    always_comb begin
        logic seen;
        seen    = 1'b0;
        grant_o = '0;
        for (int k = 0; k < N; k++) begin
            if (elig_w[k] && !seen) begin
                grant_o[k] = 1'b1;
                seen       = 1'b1;
            end
        end
        take_o = seen;
        clr_w  = (ack_i && seen) ? grant_o : '0;
    end

    // Latches: set by request, cleared by a taken acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= req_i | (pend_q & ~clr_w);
    end
endmodule

// File: rtl/ccr_core.sv
// Module: top of the ALU, condition register and interrupt gate. Source 0
// of the pending latches is the unmaskable trap, source 1 the maskable
// request. The acknowledge acts as interrupt entry when a request is up.
module ccr_core
    import ccr_pkg::*;
#(
    parameter int DW = 8,
    parameter int HB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] mem_i,
    input  logic [CC_W-1:0] pop_i,
    input  logic          trap_req_i,
    input  logic          irq_req_i,
    input  logic          svc_ack_i,
    output logic [DW-1:0] result_o,
    output logic [CC_W-1:0] cc_o,
    output logic [FL_W-1:0] flags_o,
    output logic          svc_req_o,
    output logic          svc_trap_o
);
    localparam int NSRC = 2;

    flags_t          fl_w;
    logic            n_w, z_w, c_w, h_w;
    logic            wr_nz_w, wr_c_w, wr_h_w;
    logic [NSRC-1:0] grant_w;
    logic            take_w;
    logic            enter_w;

    ccr_alu #(.DW(DW), .HB(HB)) u_alu (
        .op_i    (op_i),
        .a_i     (acc_i),
        .m_i     (mem_i),
        .c_i     (fl_w.c),
        .res_o   (result_o),
        .n_o     (n_w),
        .z_o     (z_w),
        .c_o     (c_w),
        .h_o     (h_w),
        .wr_nz_o (wr_nz_w),
        .wr_c_o  (wr_c_w),
        .wr_h_o  (wr_h_w)
    );

    ccr_pend #(.N(NSRC), .MASKABLE(2'b10)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   ({irq_req_i, trap_req_i}),
        .mask_i  (fl_w.i),
        .ack_i   (svc_ack_i),
        .grant_o (grant_w),
        .take_o  (take_w)
    );

    // Entry strobe only counts when a request is actually serviceable
    assign enter_w = svc_ack_i & take_w;

    ccr_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .pop_i   (pop_i),
        .enter_i (enter_w),
        .n_i     (n_w),
        .z_i     (z_w),
        .c_i     (c_w),
        .h_i     (h_w),
        .wr_nz_i (wr_nz_w),
        .wr_c_i  (wr_c_w),
        .wr_h_i  (wr_h_w),
        .fl_o    (fl_w)
    );

    // Output assembly: full register with constant top bits
    assign cc_o       = {CC_TOP, fl_w};
    assign flags_o    = fl_w;
    assign svc_req_o  = take_w;
    assign svc_trap_o = grant_w[0];
endmodule

// File: rtl/ccr_core_chk.sv
// Module: property checker for ccr_core, attached through bind.
module ccr_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_i,
    input logic       trap_req_i,
    input logic       svc_ack_i,
    input logic [7:0] cc_o,
    input logic       svc_req_o,
    input logic       svc_trap_o
);
    // R1: register value right after reset release
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cc_o == 8'hE8);

    // R4, R5, R7: H only moves on ADD/ADC or restore
    a_r4_h_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 4'd1 && op_i != 4'd2 && op_i != 4'd9 && op_i != 4'd10)
        |=> cc_o[4] == $past(cc_o[4]));

    // R5: logic ops and loads keep C
    a_r5_c_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6) |=> cc_o[0] == $past(cc_o[0]));

    // R7: SIM sets the mask
    a_r7_sim_sets: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 4'd7 |=> cc_o[3]);

    // R9: with the mask set only the trap can request service
    a_r9_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_o[3] && svc_req_o) |-> svc_trap_o);

    // R10: a trap request is serviceable on the next cycle regardless of mask
    a_r10_trap_served: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_i |=> (svc_req_o && svc_trap_o));

    // R11, R12: a taken acknowledge leaves the mask set
    a_r11_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ack_i && svc_req_o) |=> cc_o[3]);
endmodule

bind ccr_core ccr_core_chk u_chk (.*);

// File: tb/ccr_core_tb.sv
`timescale 1ns/1ps
module ccr_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0, mem_i = '0, pop_i = '0;
    logic       trap_req_i = 1'b0, irq_req_i = 1'b0, svc_ack_i = 1'b0;
    logic [7:0] result_o, cc_o;
    logic [4:0] flags_o;
    logic       svc_req_o, svc_trap_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Model state: flags {h,i,n,z,c} and pending latches
    logic [4:0] m_fl;
    logic       m_pt, m_pi;

    always #10 clk = ~clk;

    ccr_core u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd1, 4'd2: return "R3/R6";
            4'd3:       return "R4/R6";
            4'd4, 4'd5, 4'd6: return "R5/R6";
            4'd9, 4'd10: return "R8/R2";
            default:    return "R7";
        endcase
    endfunction

    function automatic logic [7:0] exp_res(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m, input logic c);
        case (op)
            4'd1: return a + m;
            4'd2: return a + m + {7'd0, c};
            4'd3: return a - m;
            4'd4: return a & m;
            4'd5: return a | m;
            4'd6: return m;
            default: return a;
        endcase
    endfunction

    // Next flags from the operation alone (no entry)
    function automatic logic [4:0] exp_fl(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                                          input logic [7:0] p, input logic [4:0] f);
        logic [4:0] r;
        logic [8:0] s;
        logic [4:0] hs;
        logic [7:0] v;
        logic       ci;
        r  = f;
        ci = (op == 4'd2) ? f[0] : 1'b0;
        v  = exp_res(op, a, m, f[0]);
        case (op)
            4'd1, 4'd2: begin
                s  = {1'b0, a} + {1'b0, m} + {8'd0, ci};
                hs = {1'b0, a[3:0]} + {1'b0, m[3:0]} + {4'd0, ci};
                r[4] = hs[4];
                r[0] = s[8];
            end
            4'd3: r[0] = (m > a);
            4'd7: r[3] = 1'b1;
            4'd8: r[3] = 1'b0;
            4'd9, 4'd10: r = p[4:0];
            default: ;
        endcase
        if (op >= 4'd1 && op <= 4'd6) begin
            r[2] = v[7];
            r[1] = (v == 8'd0);
        end
        return r;
    endfunction

    // One cycle: drive at negedge, check combinational outputs, clock, check state
    task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic [7:0] p, input bit trap, input bit irq, input bit ack);
        logic take, gt, gi;
        logic [4:0] nf;
        string tg;
        @(negedge clk);
        op_i = op; acc_i = a; mem_i = m; pop_i = p;
        trap_req_i = trap; irq_req_i = irq; svc_ack_i = ack;
        gt   = m_pt;
        gi   = !m_pt && m_pi && !m_fl[3];
        take = gt || gi;
        #2;
        chk(result_o == exp_res(op, a, m, m_fl[0]), op_tag(op), result_o, exp_res(op, a, m, m_fl[0]));
        chk(svc_req_o == take, "R9/R10 svc_req", {7'd0, svc_req_o}, {7'd0, take});
        chk(svc_trap_o == gt, "R10 svc_trap", {7'd0, svc_trap_o}, {7'd0, gt});
        nf = exp_fl(op, a, m, p, m_fl);
        tg = op_tag(op);
        if (ack && take) begin
            nf[3] = 1'b1;
            tg = "R11/R12";
        end
        m_pt = trap | (m_pt & !(ack && gt));
        m_pi = irq  | (m_pi & !(ack && gi));
        m_fl = nf;
        @(posedge clk);
        #2;
        chk(cc_o == {3'b111, m_fl}, tg, cc_o, {3'b111, m_fl});
        chk(flags_o == m_fl, tg, {3'd0, flags_o}, {3'd0, m_fl});
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        m_fl = 5'b01000; m_pt = 1'b0; m_pi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(cc_o == 8'hE8, "R1 cc", cc_o, 8'hE8);
        chk(svc_req_o == 1'b0, "R1 svc_req", {7'd0, svc_req_o}, 8'd0);

        // R3: half carry, carry, zero
        step(4'd1, 8'h0F, 8'h01, 8'h00, 0, 0, 0);
        step(4'd1, 8'hFF, 8'h01, 8'h00, 0, 0, 0);
        step(4'd2, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        step(4'd1, 8'h10, 8'h20, 8'h00, 0, 0, 0);
        // R4: borrow, H kept
        step(4'd3, 8'h00, 8'h01, 8'h00, 0, 0, 0);
        step(4'd3, 8'h05, 8'h05, 8'h00, 0, 0, 0);
        // R5: logic and load keep C
        step(4'd1, 8'h80, 8'h80, 8'h00, 0, 0, 0);
        step(4'd4, 8'hF0, 8'h0F, 8'h00, 0, 0, 0);
        step(4'd6, 8'h00, 8'h90, 8'h00, 0, 0, 0);
        // R9: masked request held, delivered after RIM
        step(4'd0, 8'h00, 8'h00, 8'h00, 0, 1, 0);
        step(4'd0, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(4'd8, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        // R11: ack with a same-cycle request keeps the latch pending
        step(4'd0, 8'h00, 8'h00, 8'h00, 0, 1, 1);
        step(4'd8, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        // R12: ack together with RIM leaves the mask set
        step(4'd8, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        // R10: trap while masked, priority over maskable
        step(4'd7, 8'h00, 8'h00, 8'h00, 1, 1, 0);
        step(4'd8, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        step(4'd0, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(4'd8, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        // R8, R2: restore ignores top bits; R12 with IRET clearing mask
        step(4'd9, 8'h00, 8'h00, 8'h00, 0, 0, 0);
        step(4'd10, 8'h00, 8'h00, 8'h1F, 0, 0, 0);
        step(4'd9, 8'h00, 8'h00, 8'hE0, 1, 0, 0);
        step(4'd9, 8'h00, 8'h00, 8'h00, 0, 0, 1);
        step(4'd12, 8'h55, 8'hAA, 8'h00, 0, 0, 0);

        // Constrained random phase
        for (int n = 0; n < 3000; n++) begin
            step(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom),
                 ($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 3) == 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule